// File: doc/BRIEF.md
# Companion Clock Wake Sequencer

This block brings a companion device from reset to normal operation in a fixed order. Once reset is released and the reference clock is reported present, it turns the oscillator on and takes it out of bypass. It then waits a programmable number of cycles while the loop locks. After that it enables the internal run clock and the ready signal in the same cycle, and waits a fixed settle interval. Only then does it open a gate that lets software reach the rest of the register space.

While the gate is closed, only three registers answer: the control register, the memory configuration register and the identification register. The per-function clock-enable register is blocked: it reads as zero and drops writes. It is cleared each time bring-up completes. Each of its bits then ungates one peripheral clock.

Writing the sleep bit in the control register shuts all clocks off and closes the gate again. Clearing the sleep bit starts a full new wake sequence.

Top module: `wake_sequencer`

## Requirements
- R1: After reset, oscOn, runClkEn, readyEn and bringupDone are 0, pllBypass is 1, and the control register (address 0) reads 0x04. Its bits are: bit0 sleep, bit1 oscillator on, bit2 bypass, bit3 ready enable, bit4 run clock enable.
- R2: While refClkOk is low in the waiting state, the oscillator stays off and bypass stays on.
- R3: Once refClkOk is seen high, oscOn rises and pllBypass falls in the same cycle. They hold for max(lockCycles,1) cycles before the run clock is enabled, so a lockCycles of 0 behaves as 1.
- R4: runClkEn and readyEn rise in the same cycle and are equal in every cycle.
- R5: bringupDone rises exactly SETTLE_CYC (default 14) cycles after runClkEn rises.
- R6: bringupDone is high only while oscOn and runClkEn are high, and the control register then reads 0x1A.
- R7: While bringupDone is low, addresses 0, 1 and 2 respond normally. The clock-enable register at address 3 reads 0 and ignores writes.
- R8: Address 2 reads the constant {CHIP_ID[23:0], SI_REV[3:0] in bits 7:4, MT_REV[3:0] in bits 3:0}.
- R9: When bring-up completes, the clock-enable register is 0. Writing a value to it drives periphClkEn to that value from the next cycle. periphClkEn is 0 whenever bringupDone is low.
- R10: Writing 1 to control bit 0 turns off oscOn, runClkEn, readyEn and bringupDone one cycle after the write takes effect, and they stay off. Writing 0 to it then runs the full R3 and R5 sequence again and clears the clock-enable register.
- R11: Addresses 4 to 7 read 0, and regRdata is 0 whenever regRd is low.
- R12: Address 1 reads back the low MEMCFG_W bits last written, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low synchronous reset |
| refClkOk | input | 1 | Reference clock present |
| lockCycles | input | LOCK_W | Lock wait length in cycles |
| regAddr | input | 3 | Register word address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read enable |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data (combinational) |
| oscOn | output | 1 | Oscillator enable |
| pllBypass | output | 1 | Loop bypass select |
| runClkEn | output | 1 | Internal run clock enable |
| readyEn | output | 1 | Ready signal enable |
| bringupDone | output | 1 | Register gate open |
| periphClkEn | output | NUM_FUNC | Per-function clock enables |

## Verification
A register write takes effect at the rising edge inside the write cycle. Its result is read back at the falling edge that follows. A sleep write reaches the clock outputs one cycle after that, so the bench waits one extra falling edge before it samples them. The lock and settle phases are timed by counting falling-edge samples in which the phase's output pattern holds, instead of waiting for fixed absolute cycles. This gives exact lengths of max(lockCycles,1) and 14 cycles. Reads are combinational and are sampled 1 ns after the address is driven, away from any clock edge.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;

  // Register word addresses; the gate decision depends on these values.
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MEM  = 3'd1,
    A_ID   = 3'd2,
    A_GATE = 3'd3
  } regAddr_t;

  typedef enum logic [2:0] {
    ST_WAIT_REF = 3'd0,
    ST_LOCK     = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_OPEN     = 3'd3,
    ST_SLEEP    = 3'd4
  } seqState_t;

  // Strobes from the sequencer control to the register datapath.
  typedef struct packed {
    logic oscOn;
    logic bypass;
    logic runClkEn;
    logic readyEn;
    logic accessOpen;
    logic clearGates;
  } seqStrobe_t;

endpackage

// File: rtl/wake_ctrl.sv
`timescale 1ns/1ps
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int LOCK_W     = 16,
  parameter int SETTLE_CYC = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClkOk,
  input  logic              sleepBit,
  input  logic [LOCK_W-1:0] lockCycles,
  output seqStrobe_t        strb
);

  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int CNT_W = (LOCK_W > SET_W) ? LOCK_W : SET_W;

  seqState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [CNT_W-1:0] lockLen;
  logic             clearD;

  // A zero lock length still spends one cycle in lock.
  always_comb begin
    lockLen = (lockCycles == '0) ? CNT_W'(1) : CNT_W'(lockCycles);
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    clearD = 1'b0;
    unique case (stateQ)
      ST_WAIT_REF: begin
        if (refClkOk) begin
          stateD = ST_LOCK;
          cntD   = '0;
        end
      end
      ST_LOCK: begin
        if (({1'b0, cntQ} + 1'b1) >= {1'b0, lockLen}) begin
          stateD = ST_SETTLE;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cntQ == CNT_W'(SETTLE_CYC - 1)) begin
          stateD = ST_OPEN;
          clearD = 1'b1;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_OPEN: stateD = ST_OPEN;
      ST_SLEEP: begin
        if (!sleepBit) stateD = ST_WAIT_REF;
      end
      default: stateD = ST_WAIT_REF;
    endcase
    // Sleep overrides every other transition.
    if (sleepBit && stateQ != ST_SLEEP) begin
      stateD = ST_SLEEP;
      clearD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_WAIT_REF;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  logic oscPhase, runPhase;
  always_comb begin
    oscPhase = (stateQ == ST_LOCK) || (stateQ == ST_SETTLE) || (stateQ == ST_OPEN);
    runPhase = (stateQ == ST_SETTLE) || (stateQ == ST_OPEN);
    strb.oscOn      = oscPhase;
    strb.bypass     = !oscPhase;
    strb.runClkEn   = runPhase;
    strb.readyEn    = runPhase;
    strb.accessOpen = (stateQ == ST_OPEN);
    strb.clearGates = clearD;
  end

endmodule

// File: rtl/wake_regs.sv
`timescale 1ns/1ps
module wake_regs
  import wake_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NUM_FUNC = 8,
  parameter int          MEMCFG_W = 12,
  parameter logic [31:0] ID_WORD  = 32'h0
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [2:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                sleepBit,
  output logic [NUM_FUNC-1:0] periphClkEn
);

  logic [MEMCFG_W-1:0] memCfgQ;
  logic [NUM_FUNC-1:0] gateQ;
  logic                wrCtrl, wrMem, wrGate;
  logic                unusedWdata;

  assign unusedWdata = &{1'b0, regWdata};

  always_comb begin
    wrCtrl = regWr && (regAddr == A_CTRL);
    wrMem  = regWr && (regAddr == A_MEM);
    wrGate = regWr && (regAddr == A_GATE) && strb.accessOpen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepBit <= 1'b0;
      memCfgQ  <= '0;
      gateQ    <= '0;
    end else begin
      if (wrCtrl) sleepBit <= regWdata[0];
      if (wrMem)  memCfgQ  <= regWdata[MEMCFG_W-1:0];
      if (strb.clearGates)  gateQ <= '0;
      else if (wrGate)      gateQ <= regWdata[NUM_FUNC-1:0];
    end
  end

  // Per-function enables: held off until the gate opens.
  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_gate
    assign periphClkEn[g] = gateQ[g] & strb.accessOpen;
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      unique case (regAddr)
        A_CTRL: regRdata = DATA_W'({strb.runClkEn, strb.readyEn, strb.bypass,
                                    strb.oscOn, sleepBit});
        A_MEM:  regRdata = DATA_W'(memCfgQ);
        A_ID:   regRdata = DATA_W'(ID_WORD);
        A_GATE: regRdata = strb.accessOpen ? DATA_W'(gateQ) : '0;
        default: regRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wake_sequencer.sv
`timescale 1ns/1ps
module wake_sequencer
  import wake_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          NUM_FUNC   = 8,
  parameter int          MEMCFG_W   = 12,
  parameter int          LOCK_W     = 16,
  parameter int          SETTLE_CYC = 14,
  parameter logic [23:0] CHIP_ID    = 24'hC0DE42,
  parameter logic [3:0]  SI_REV     = 4'h3,
  parameter logic [3:0]  MT_REV     = 4'h1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refClkOk,
  input  logic [LOCK_W-1:0]   lockCycles,
  input  logic [2:0]          regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                oscOn,
  output logic                pllBypass,
  output logic                runClkEn,
  output logic                readyEn,
  output logic                bringupDone,
  output logic [NUM_FUNC-1:0] periphClkEn
);

  localparam logic [31:0] ID_WORD = {CHIP_ID, SI_REV, MT_REV};

  seqStrobe_t strb;
  logic       sleepBit;

  wake_ctrl #(
    .LOCK_W    (LOCK_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refClkOk  (refClkOk),
    .sleepBit  (sleepBit),
    .lockCycles(lockCycles),
    .strb      (strb)
  );

  wake_regs #(
    .DATA_W  (DATA_W),
    .NUM_FUNC(NUM_FUNC),
    .MEMCFG_W(MEMCFG_W),
    .ID_WORD (ID_WORD)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regWr      (regWr),
    .regRd      (regRd),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .sleepBit   (sleepBit),
    .periphClkEn(periphClkEn)
  );

  assign oscOn       = strb.oscOn;
  assign pllBypass   = strb.bypass;
  assign runClkEn    = strb.runClkEn;
  assign readyEn     = strb.readyEn;
  assign bringupDone = strb.accessOpen;

endmodule

// File: rtl/wake_sequencer_chk.sv
`timescale 1ns/1ps
module wake_sequencer_chk #(
  parameter int          DATA_W     = 32,
  parameter int          NUM_FUNC   = 8,
  parameter int          SETTLE_CYC = 14,
  parameter logic [31:0] ID_WORD    = 32'h0
) (
  input logic                clk,
  input logic                rstN,
  input logic                refClkOk,
  input logic [2:0]          regAddr,
  input logic                regWr,
  input logic                regRd,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic                oscOn,
  input logic                runClkEn,
  input logic                bringupDone,
  input logic [NUM_FUNC-1:0] periphClkEn
);

  int settleCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !runClkEn) settleCnt <= 0;
    else if (!bringupDone)  settleCnt <= settleCnt + 1;
  end

  // R3
  osc_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscOn) |-> $past(refClkOk));

  // R3
  run_after_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runClkEn) |-> $past(oscOn));

  // R5
  settle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bringupDone) |-> (settleCnt == SETTLE_CYC));

  // R7
  gate_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd3 && !bringupDone) |-> (regRdata == '0));

  // R8
  id_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 3'd2) |-> (regRdata == DATA_W'(ID_WORD)));

  // R9
  periph_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bringupDone |-> (periphClkEn == '0));

  // R10
  sleep_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd0 && regWdata[0]) |=> ##1 (!oscOn && !runClkEn && !bringupDone));

endmodule

bind wake_sequencer wake_sequencer_chk #(
  .DATA_W    (DATA_W),
  .NUM_FUNC  (NUM_FUNC),
  .SETTLE_CYC(SETTLE_CYC),
  .ID_WORD   (ID_WORD)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refClkOk   (refClkOk),
  .regAddr    (regAddr),
  .regWr      (regWr),
  .regRd      (regRd),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .oscOn      (oscOn),
  .runClkEn   (runClkEn),
  .bringupDone(bringupDone),
  .periphClkEn(periphClkEn)
);

// File: tb/sim_wake_sequencer.sv
`timescale 1ns/1ps
module sim_wake_sequencer;

  localparam int DATA_W = 32;
  localparam int NF     = 8;
  localparam int LW     = 16;
  localparam logic [31:0] EXP_ID = 32'hC0DE4231;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refClkOk = 1'b0;
  logic [LW-1:0] lockCycles = '0;
  logic [2:0]    regAddr = '0;
  logic          regWr = 1'b0;
  logic          regRd = 1'b0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic          oscOn, pllBypass, runClkEn, readyEn, bringupDone;
  logic [NF-1:0] periphClkEn;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  wake_sequencer u0 (
    .clk(clk), .rstN(rstN), .refClkOk(refClkOk), .lockCycles(lockCycles),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .oscOn(oscOn), .pllBypass(pllBypass),
    .runClkEn(runClkEn), .readyEn(readyEn), .bringupDone(bringupDone),
    .periphClkEn(periphClkEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    regRd = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; refClkOk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Counts falling-edge samples of each phase until the gate opens.
  task automatic measure(output int lockSeen, output int settleSeen, output int bad);
    lockSeen = 0; settleSeen = 0; bad = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (oscOn && !runClkEn) lockSeen++;
      if (runClkEn && !bringupDone) settleSeen++;
      if (runClkEn !== readyEn) bad++;
      if (pllBypass !== !oscOn) bad++;
      if (bringupDone) break;
    end
  endtask

  task automatic bringUp(input int lockLen, input string tag);
    int l, s, b;
    refClkOk = 1'b1;
    measure(l, s, b);
    check({tag, " R3 lock length"}, l, (lockLen == 0) ? 1 : lockLen);
    check({tag, " R4 run/ready pairing"}, b, 0);
    check({tag, " R5 settle length"}, s, 14);
    check({tag, " R6 done with clocks"}, {bringupDone, oscOn, runClkEn}, 3'b111);
  endtask

  task automatic testReset();
    logic [31:0] d;
    doReset();
    check("R1 outputs", {oscOn, pllBypass, runClkEn, readyEn, bringupDone}, 5'b01000);
    regRead(3'd0, d); check("R1 ctrl reset", d, 32'h04);
  endtask

  task automatic testRefWait();
    repeat (20) @(negedge clk);
    check("R2 osc off without ref", {oscOn, pllBypass}, 2'b01);
  endtask

  task automatic testBlockedAccess();
    logic [31:0] d;
    regWrite(3'd3, 32'hFF);
    regRead(3'd3, d); check("R7 gate blocked read", d, 0);
    check("R9 periph off before done", periphClkEn, 0);
    regWrite(3'd1, 32'hABC);
    regRead(3'd1, d); check("R7 R12 memcfg open before done", d, 32'hABC);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, d); check("R12 memcfg width", d, 32'hFFF);
    regRead(3'd2, d); check("R8 id word", d, EXP_ID);
    regRead(3'd0, d); check("R7 ctrl open before done", d, 32'h04);
  endtask

  task automatic testOpenAccess();
    logic [31:0] d;
    regRead(3'd3, d); check("R9 gate cleared at done", d, 0);
    regRead(3'd0, d); check("R6 ctrl when done", d, 32'h1A);
    regWrite(3'd3, 32'h0000_00A5);
    check("R9 periph enables", periphClkEn, 8'hA5);
    regRead(3'd3, d); check("R9 gate readback", d, 32'hA5);
    regWrite(3'd3, 32'h0000_0002);
    check("R9 single enable", periphClkEn, 8'h02);
    regWrite(3'd3, 32'h0000_00C3);
  endtask

  task automatic testSleep();
    logic [31:0] d;
    regWrite(3'd0, 32'h1);
    regRead(3'd0, d); check("R10 sleep bit set", d[0], 1'b1);
    @(negedge clk);
    check("R10 clocks off", {oscOn, runClkEn, readyEn, bringupDone}, 4'b0000);
    check("R10 periph off in sleep", periphClkEn, 0);
    repeat (10) @(negedge clk);
    check("R10 stays asleep", {oscOn, bringupDone, pllBypass}, 3'b001);
    regRead(3'd3, d); check("R7 gate blocked in sleep", d, 0);
    regWrite(3'd0, 32'h0);
    bringUp(lockCycles, "R10 rewake");
    regRead(3'd3, d); check("R10 gates cleared after rewake", d, 0);
    check("R10 periph off after rewake", periphClkEn, 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    for (int a = 4; a < 8; a++) begin
      regRead(3'(a), d); check("R11 unmapped read", d, 0);
    end
    regAddr = 3'd2; regRd = 1'b0;
    #1 check("R11 idle read data", regRdata, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    lockCycles = 16'd5;
    testReset();
    testRefWait();
    testBlockedAccess();
    bringUp(5, "L5");
    testOpenAccess();
    testUnmapped();
    testSleep();

    lockCycles = 16'd0;
    doReset();
    bringUp(0, "L0");

    lockCycles = 16'd37;
    doReset();
    bringUp(37, "L37");
    testOpenAccess();

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule